// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single-cycle access requests from an internal master into bus cycles on an 8-bit multiplexed address/data bus. Every request carries a 16-bit address, a read/write flag and write data. The block first decodes the address into one of four regions: register RAM, code RAM, internal program memory, or external space. The decoded region is shown on a port so that the internal memories, which are outside this block, can be selected. Internal accesses finish one cycle after they are accepted, and their read data comes from the internal read-data input. Only external addresses start a bus cycle.

An external cycle has three parts. First comes an address clock, in which the low address byte is driven on the multiplexed lines and the latch pin is asserted. Next comes a strobe window, in which the read or write strobe is low. Last comes a recovery clock, which follows the trailing strobe edge and carries the done pulse. The latch pin has two behaviours. As an address-latch strobe it is a short high pulse. As an address-valid output it stays low for the whole cycle and can therefore act as a chip select. A configured wait count lengthens the strobe window. The forbidden wait code is handled as the largest legal count. The block also outputs a clock at half the oscillator rate.

The configuration inputs are expected to stay static while a cycle is in progress.

Top module: `mux_bus_ctrl`

## Requirements
- R1: `region` decodes `addr` combinationally. Code 0 is register RAM, for 0018h–03FFh and 1C00h–1DFFh. Code 1 is code RAM, for 0400h–05FFh. Code 2 is program memory. Code 3 is external, which covers every address not listed.
- R2: A request accepted for a non-external address sets `done` high for exactly one clock, in the clock after acceptance. For a read, `rdata` then equals the `int_rdata` value sampled at acceptance. Neither strobe and not the latch pin become active.
- R3: An external read drives `ad_out` = addr[7:0] with `ad_oe` = 1 and `addr_hi` = addr[15:8] in the address clock. In the strobe window, `rd_n` is low and `ad_oe` is 0. `rdata` then holds the `ad_in` value sampled at the last strobe clock.
- R4: An external write holds `wr_n` low in the strobe window. `ad_out` carries the write data with `ad_oe` = 1 throughout the strobe window and the recovery clock.
- R5: With `cfg_adv` = 0, `latch` is high for exactly the one address clock of an external cycle and low at all other times.
- R6: With `cfg_adv` = 1, `latch` is low from the address clock through the recovery clock and high at all other times.
- R7: With `w` the effective wait count, the strobe window lasts 2 + 2·w clocks, which means w extra `clkout` periods. `done` rises in clock 4 + 2·w after acceptance.
- R8: A `cfg_wait` code of 7 acts exactly like code 6.
- R9: `clkout` is low during reset and toggles on every clock after reset, giving half the clock rate at a 50% duty cycle.
- R10: A request raised while an external cycle is in progress is ignored. The cycle in progress completes unchanged, and no second cycle follows it.
- R11: `rd_n` and `wr_n` are never low together, and both are high whenever no external cycle is in its strobe window.
- R12: The range 2000h–DFFFh decodes as program memory (code 2) when `ext_access` = 1 and as external (code 3) when `ext_access` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-clock access request, taken only when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| int_rdata | input | 8 | Read data from internal memories |
| ext_access | input | 1 | 1 maps 2000h–DFFFh to program memory |
| cfg_adv | input | 1 | Latch pin mode: 0 strobe, 1 address-valid |
| cfg_wait | input | 3 | Wait count; code 7 behaves as 6 |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read result |
| region | output | 2 | Decoded region of `addr` |
| clkout | output | 1 | Half-rate clock output |
| latch | output | 1 | Address latch / address-valid pin |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Multiplexed bus output value |
| ad_oe | output | 1 | Multiplexed bus output enable |
| ad_in | input | 8 | Multiplexed bus input value |
| addr_hi | output | 8 | High address byte |

## Verification
Some properties are checked on every clock:
- the strobes never overlap;
- the read strobe never coincides with a driven bus;
- `done` stays a single pulse;
- in strobe mode the latch pulse and the strobes are exclusive;
- in address-valid mode the latch pin is held low under an active strobe;
- each strobe window has the length that the wait code implies, including code 7;
- `clkout` alternates on every clock.

The bench scenarios cover the rest: the region decode at its boundaries and under both `ext_access` settings, the address and data values carried on the bus, read data captured from the bus or from internal memory, the total cycle length, and the rejection of a request that arrives in the middle of a cycle.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int BUS_ADDR_W = 16;
    localparam int BUS_DATA_W = 8;
    localparam int WAIT_CODE_W = 3;

    typedef enum logic [1:0] {
        RGN_REGRAM  = 2'd0,
        RGN_CODERAM = 2'd1,
        RGN_PROG    = 2'd2,
        RGN_EXT     = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ADDR    = 2'd1,
        PH_STROBE  = 2'd2,
        PH_RECOVER = 2'd3
    } phase_e;

    // address map bounds (inclusive)
    localparam logic [BUS_ADDR_W-1:0] REGRAM_A_LO = 16'h0018;
    localparam logic [BUS_ADDR_W-1:0] REGRAM_A_HI = 16'h03FF;
    localparam logic [BUS_ADDR_W-1:0] CODERAM_LO  = 16'h0400;
    localparam logic [BUS_ADDR_W-1:0] CODERAM_HI  = 16'h05FF;
    localparam logic [BUS_ADDR_W-1:0] REGRAM_B_LO = 16'h1C00;
    localparam logic [BUS_ADDR_W-1:0] REGRAM_B_HI = 16'h1DFF;
    localparam logic [BUS_ADDR_W-1:0] PROG_LO     = 16'h2000;
    localparam logic [BUS_ADDR_W-1:0] PROG_HI     = 16'hDFFF;

endpackage

// File: rtl/mbc_region_dec.sv
module mbc_region_dec
    import mbc_pkg::*;
(
    input  logic [BUS_ADDR_W-1:0] addr,
    input  logic                  ext_access,
    output region_e               region
);

    logic in_reg_a, in_reg_b, in_code, in_prog;

    always_comb begin
        in_reg_a = (addr >= REGRAM_A_LO) && (addr <= REGRAM_A_HI);
        in_reg_b = (addr >= REGRAM_B_LO) && (addr <= REGRAM_B_HI);
        in_code  = (addr >= CODERAM_LO)  && (addr <= CODERAM_HI);
        in_prog  = (addr >= PROG_LO)     && (addr <= PROG_HI) && ext_access;

        if (in_reg_a || in_reg_b) begin
            region = RGN_REGRAM;
        end else if (in_code) begin
            region = RGN_CODERAM;
        end else if (in_prog) begin
            region = RGN_PROG;
        end else begin
            region = RGN_EXT;
        end
    end

endmodule

// File: rtl/mbc_wait_len.sv
module mbc_wait_len #(
    parameter int WAIT_W        = 3,
    parameter bit CLAMP_ILLEGAL = 1'b1,
    localparam int LEN_W        = WAIT_W + 2
) (
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic [LEN_W-1:0]  strobe_len
);

    localparam logic [WAIT_W-1:0] CODE_ALL_ONES = {WAIT_W{1'b1}};
    localparam logic [WAIT_W-1:0] CODE_MAX_OK   = CODE_ALL_ONES - 1'b1;

    logic [WAIT_W-1:0] eff_wait;

    generate
        if (CLAMP_ILLEGAL) begin : g_clamp
            // the all-ones code is illegal: fold it onto the largest legal count
            always_comb begin
                eff_wait = (cfg_wait == CODE_ALL_ONES) ? CODE_MAX_OK : cfg_wait;
            end
        end else begin : g_pass
            always_comb begin
                eff_wait = cfg_wait;
            end
        end
    endgenerate

    // each wait state adds one output-clock period = two oscillator clocks
    always_comb begin
        strobe_len = LEN_W'({eff_wait, 1'b0}) + LEN_W'(2);
    end

endmodule

// File: rtl/mbc_clkdiv.sv
module mbc_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic clkout
);

    logic div_d, div_q;

    always_comb begin
        div_d = ~div_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign clkout = div_q;

    // R9: alternates on every clock once out of reset
    p_clkout_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (clkout != $past(clkout)));

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W,
    parameter int WAIT_W = WAIT_CODE_W,
    localparam int HI_W  = ADDR_W - DATA_W,
    localparam int LEN_W = WAIT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] int_rdata,
    input  logic              ext_access,
    input  logic              cfg_adv,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        region,
    output logic              clkout,
    output logic              latch,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   addr_hi
);

    typedef struct packed {
        phase_e            phase;
        logic [LEN_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } state_t;

    state_t  st_d, st_q;
    region_e rgn;
    logic [LEN_W-1:0] strobe_len;

    mbc_region_dec u_dec (
        .addr       (addr),
        .ext_access (ext_access),
        .region     (rgn)
    );

    mbc_wait_len #(
        .WAIT_W        (WAIT_W),
        .CLAMP_ILLEGAL (1'b1)
    ) u_wait (
        .cfg_wait   (cfg_wait),
        .strobe_len (strobe_len)
    );

    mbc_clkdiv u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .clkout (clkout)
    );

    // next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req) begin
                    st_d.wr    = wr;
                    st_d.addr  = addr;
                    st_d.wdata = wdata;
                    if (rgn != RGN_EXT) begin
                        st_d.done = 1'b1;
                        if (!wr) begin
                            st_d.rdata = int_rdata;
                        end
                    end else begin
                        st_d.phase = PH_ADDR;
                        st_d.cnt   = strobe_len - LEN_W'(1);
                    end
                end
            end
            PH_ADDR: begin
                st_d.phase = PH_STROBE;
            end
            PH_STROBE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_RECOVER;
                    st_d.done  = 1'b1;
                    if (!st_q.wr) begin
                        st_d.rdata = ad_in;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - LEN_W'(1);
                end
            end
            PH_RECOVER: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, wr: 1'b0, addr: '0,
                      wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // pin decode from the phase register
    logic in_strobe;

    always_comb begin
        in_strobe = (st_q.phase == PH_STROBE);
        rd_n      = !(in_strobe && !st_q.wr);
        wr_n      = !(in_strobe && st_q.wr);
        if (cfg_adv) begin
            latch = (st_q.phase == PH_IDLE);
        end else begin
            latch = (st_q.phase == PH_ADDR);
        end
        ad_oe  = (st_q.phase == PH_ADDR) ||
                 (st_q.wr && (in_strobe || st_q.phase == PH_RECOVER));
        ad_out = (st_q.phase == PH_ADDR) ? st_q.addr[DATA_W-1:0] : st_q.wdata;
    end

    assign addr_hi = st_q.addr[ADDR_W-1:DATA_W];
    assign done    = st_q.done;
    assign rdata   = st_q.rdata;
    assign region  = rgn;

    // ---------------------------------------------------------------
    // assertions
    // ---------------------------------------------------------------
    logic [LEN_W-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!rd_n || !wr_n) begin
            low_cnt <= low_cnt + LEN_W'(1);
        end else begin
            low_cnt <= '0;
        end
    end

    function automatic logic [LEN_W-1:0] chk_window(input logic [WAIT_W-1:0] code);
        logic [LEN_W-1:0] n;
        n = LEN_W'(code);
        if (code == {WAIT_W{1'b1}}) begin
            n = n - LEN_W'(1);
        end
        return LEN_W'(2) + n + n;
    endfunction

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_read_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_int_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && req && region != 2'd3) |=> (done && rd_n && wr_n));

    p_ale_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_adv && latch) |-> (rd_n && wr_n));

    p_adv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_adv && (!rd_n || !wr_n)) |-> !latch);

    // R7 and R8: strobe window length from the wait code
    p_wait_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> (low_cnt == chk_window(cfg_wait)));

endmodule

// File: tb/mux_bus_ctrl_test.sv
module mux_bus_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req, wr, ext_access, cfg_adv;
    logic [15:0] addr;
    logic [7:0] wdata, int_rdata, ad_in;
    logic [2:0] cfg_wait;
    logic       done, clkout, latch, rd_n, wr_n, ad_oe;
    logic [7:0] rdata, ad_out, addr_hi;
    logic [1:0] region;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mux_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .int_rdata(int_rdata), .ext_access(ext_access),
        .cfg_adv(cfg_adv), .cfg_wait(cfg_wait), .done(done), .rdata(rdata),
        .region(region), .clkout(clkout), .latch(latch), .rd_n(rd_n),
        .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .addr_hi(addr_hi)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_region(input logic [15:0] a, input logic ea);
        if ((a >= 16'h0018 && a <= 16'h03FF) || (a >= 16'h1C00 && a <= 16'h1DFF)) return 0;
        if (a >= 16'h0400 && a <= 16'h05FF) return 1;
        if (a >= 16'h2000 && a <= 16'hDFFF && ea) return 2;
        return 3;
    endfunction

    function automatic int eff_wait(input logic [2:0] c);
        return (c == 3'd7) ? 6 : int'(c);
    endfunction

    function automatic bit in_prog_range(input logic [15:0] a);
        return (a >= 16'h2000 && a <= 16'hDFFF);
    endfunction

    task automatic chk_region(input logic [15:0] a, input logic ea);
        @(negedge clk);
        addr = a;
        ext_access = ea;
        #1;
        check(int'(region) == exp_region(a, ea), in_prog_range(a) ? "R12 region" : "R1 region",
              region, exp_region(a, ea));
    endtask

    task automatic run_access(input logic [15:0] a, input logic w, input logic [7:0] d,
                              input logic [7:0] idat, input logic [7:0] xdat, input bit disturb);
        int rgn, wl, done_k, lat_cnt, rd_cnt, wr_cnt, oe_bad, dat_bad;
        bit addr_ok;
        logic [7:0] got;
        logic adv_mode;
        rgn = 0; wl = 0; done_k = 0; lat_cnt = 0; rd_cnt = 0; wr_cnt = 0;
        oe_bad = 0; dat_bad = 0; addr_ok = 1'b0; got = '0;
        adv_mode = cfg_adv;
        wl = eff_wait(cfg_wait);
        @(negedge clk);
        addr = a; wr = w; wdata = d; int_rdata = idat; ad_in = xdat; req = 1'b1;
        #1;
        rgn = exp_region(a, ext_access);
        check(int'(region) == rgn, in_prog_range(a) ? "R12 access region" : "R1 access region",
              region, rgn);
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            if (k == 1) addr_ok = ad_oe && (ad_out == a[7:0]) && (addr_hi == a[15:8]);
            if (latch == (adv_mode ? 1'b0 : 1'b1)) lat_cnt++;
            if (!rd_n) begin
                rd_cnt++;
                if (ad_oe) oe_bad++;
            end
            if (!wr_n) begin
                wr_cnt++;
                if (!ad_oe || ad_out != d) dat_bad++;
            end
            if (disturb && k == 2) begin
                req = 1'b1;
                addr = ~a;
            end
            if (disturb && k == 3) req = 1'b0;
            if (done) begin
                done_k = k;
                got = rdata;
                if (rgn == 3 && w && (!ad_oe || ad_out != d)) dat_bad++;
                break;
            end
            @(negedge clk);
        end
        if (rgn == 3) begin
            check(done_k == 4 + 2 * wl, (cfg_wait == 3'd7) ? "R8 cycle length" : "R7 cycle length",
                  done_k, 4 + 2 * wl);
            if (adv_mode) check(lat_cnt == done_k, "R6 address-valid span", lat_cnt, done_k);
            else          check(lat_cnt == 1, "R5 latch pulse", lat_cnt, 1);
            if (w) begin
                check(addr_ok, "R4 address clock", addr_ok, 1);
                check(wr_cnt == 2 + 2 * wl && rd_cnt == 0, "R4 write strobe", wr_cnt, 2 + 2 * wl);
                check(dat_bad == 0, "R4 write data", dat_bad, 0);
            end else begin
                check(addr_ok, "R3 address clock", addr_ok, 1);
                check(rd_cnt == 2 + 2 * wl && wr_cnt == 0, "R3 read strobe", rd_cnt, 2 + 2 * wl);
                check(oe_bad == 0, "R3 bus released", oe_bad, 0);
                check(got == xdat, "R3 read data", got, xdat);
            end
        end else begin
            check(done_k == 1, "R2 internal done", done_k, 1);
            check(lat_cnt == 0 && rd_cnt == 0 && wr_cnt == 0, "R2 no bus activity",
                  lat_cnt + rd_cnt + wr_cnt, 0);
            if (!w) check(got == idat, "R2 internal data", got, idat);
        end
        @(negedge clk);
        check(rd_n && wr_n && !done && (latch == adv_mode),
              disturb ? "R10 no second cycle" : "R11 idle pins",
              {rd_n, wr_n, done, latch}, {1'b1, 1'b1, 1'b0, adv_mode});
        if (disturb) begin
            @(negedge clk);
            check(rd_n && wr_n && !done && (latch == adv_mode), "R10 still idle",
                  {rd_n, wr_n, done, latch}, {1'b1, 1'b1, 1'b0, adv_mode});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic prev;
        void'($urandom(32'd4711));
        rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; int_rdata = '0;
        ad_in = '0; ext_access = 1'b1; cfg_adv = 1'b0; cfg_wait = 3'd0;
        repeat (3) @(negedge clk);
        check(rd_n && wr_n, "R11 reset strobes", {rd_n, wr_n}, 3);
        check(!done && !ad_oe && !latch, "R5 reset pins", {done, ad_oe, latch}, 0);
        check(!clkout, "R9 reset clkout", clkout, 0);
        rst_n = 1'b1;

        // R9: half-rate clock output
        @(negedge clk);
        prev = clkout;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(clkout != prev, "R9 clkout toggle", clkout, !prev);
            prev = clkout;
        end

        // R1 / R12: map boundaries
        chk_region(16'h0017, 1'b1);
        chk_region(16'h0018, 1'b1);
        chk_region(16'h03FF, 1'b1);
        chk_region(16'h0400, 1'b1);
        chk_region(16'h05FF, 1'b1);
        chk_region(16'h0600, 1'b1);
        chk_region(16'h1BFF, 1'b1);
        chk_region(16'h1C00, 1'b1);
        chk_region(16'h1DFF, 1'b1);
        chk_region(16'h1E00, 1'b1);
        chk_region(16'h2000, 1'b1);
        chk_region(16'hDFFF, 1'b1);
        chk_region(16'hE000, 1'b1);
        chk_region(16'h2000, 1'b0);
        chk_region(16'hDFFF, 1'b0);

        // directed accesses
        ext_access = 1'b1; cfg_adv = 1'b0; cfg_wait = 3'd0;
        run_access(16'hE123, 1'b0, 8'h00, 8'h00, 8'h5A, 1'b0);
        run_access(16'hF0A5, 1'b1, 8'hC3, 8'h00, 8'h00, 1'b0);
        run_access(16'h0100, 1'b0, 8'h00, 8'h77, 8'h11, 1'b0);
        run_access(16'h0500, 1'b1, 8'h99, 8'h00, 8'h00, 1'b0);
        cfg_wait = 3'd7;
        run_access(16'hE800, 1'b0, 8'h00, 8'h00, 8'hA6, 1'b0);
        cfg_adv = 1'b1;
        @(negedge clk);
        run_access(16'hFFFF, 1'b1, 8'h3C, 8'h00, 8'h00, 1'b0);
        cfg_wait = 3'd6;
        run_access(16'h0000, 1'b0, 8'h00, 8'h00, 8'h81, 1'b1);
        ext_access = 1'b0;
        run_access(16'h4000, 1'b0, 8'h00, 8'h12, 8'h34, 1'b0);
        cfg_adv = 1'b0; cfg_wait = 3'd2;
        @(negedge clk);
        run_access(16'hDFFF, 1'b1, 8'h55, 8'h00, 8'h00, 1'b1);

        // constrained random accesses
        for (int n = 0; n < 60; n++) begin
            logic [15:0] ra;
            @(negedge clk);
            cfg_wait   = 3'($urandom_range(0, 7));
            cfg_adv    = 1'($urandom_range(0, 1));
            ext_access = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0: ra = 16'($urandom_range(16'h0018, 16'h03FF));
                1: ra = 16'($urandom_range(16'h0400, 16'h05FF));
                default: ra = 16'($urandom_range(0, 16'hFFFF));
            endcase
            run_access(ra, 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                       8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
                       (exp_region(ra, ext_access) == 3) && ($urandom_range(0, 3) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule